// File: doc/BRIEF.md
# Pipeline Reservation-Table Collision Analyzer

This block holds two small reservation tables and works out how they may share a pipeline. In each table a row stands for one resource (fetch, decode, execute, write-back, an extra pipeline, or a register-access row that keeps register use in program order), and a column stands for one clock cycle. A set bit means that the resource is occupied in that cycle. Every row is treated alike, so a register-access row forbids a latency exactly as a stage row does.

After a start pulse, the block sweeps one offset per clock. For the base table it builds the collision vector. A latency K is forbidden when some row is busy in column t and also in column t+K, which is the table overlaid on a copy of itself shifted by K. In the same sweep it finds the smallest shift at which a second table can follow the base table without any busy cell of the second table landing on a busy cell of the base table. The base table is the earlier entrant, so it keeps its cells and only the second table is moved later. A delayed-branch slot is modelled by including the slot instruction's cells in the branch's table. When no shift inside the table width works, a saturation flag is raised.

Rows are written one at a time through a simple write port, and any write discards earlier results. Results are valid while the done flag is high.

Top module: `rcan_top`

## Requirements
- R1: After reset, busy and done are 0, coll_vec is all zeros, app_off is 0 and app_sat is 0.
- R2: A cycle with wr_en high writes wr_data into row wr_row of the base table (wr_sel=0) or the second table (wr_sel=1), with bit c of wr_data marking column c busy. On the next edge it also clears done, busy, coll_vec, app_off and app_sat.
- R3: When start is high and wr_en is low at edge E, busy is 1 from E. At edge E+COLS busy falls and done rises. Done then stays high until the next write or start.
- R4: When done is high, bit K-1 of coll_vec (K from 1 to COLS-1) is 1 exactly when some base-table row has set bits in both column t and column t+K for some t.
- R5: All rows take part in the collision check identically, so bits set only in the last row (ROWS-1) still mark forbidden latencies.
- R6: When done is high, app_off is the smallest S in 0..COLS-1 such that no row has bit t set in the second table while bit t+S is set in the base table. An empty second table gives 0.
- R7: When no S in 0..COLS-1 is free of collisions, app_sat is 1 and app_off equals COLS once done is high. Otherwise app_sat is 0.
- R8: When wr_en and start are both high in the same cycle, the write takes effect and the start is ignored: busy stays 0 and no sweep runs.
- R9: A start that arrives during a sweep restarts the sweep from offset 0. Done then rises COLS edges after the new start, with results for the tables as they are at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Row write strobe; also clears results |
| wr_sel | input | 1 | 0 = base table, 1 = second table |
| wr_row | input | $clog2(ROWS) | Row index to write |
| wr_data | input | COLS | Row contents, bit c = column c busy |
| start | input | 1 | Begin (or restart) the offset sweep |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Results valid |
| coll_vec | output | COLS-1 | Bit K-1 set = latency K forbidden |
| app_off | output | $clog2(COLS+1) | Smallest collision-free append shift |
| app_sat | output | 1 | No shift below COLS is collision-free |

## Verification
Two pairs of functions can meet in one cycle. A row write can land in the same cycle as a start, and a start can land in the middle of a running sweep. The bench drives wr_en and start together, then checks that busy stays low and all results stay zero. It also pulses start again halfway through a sweep and checks that done rises exactly COLS edges after the second pulse. A behavioural model kept in the bench predicts busy and done on every clock and recomputes the collision vector and append shift by plain loops over the tables.

// File: rtl/rcan_pkg.sv
package rcan_pkg;
  typedef enum logic [1:0] {
    SW_IDLE = 2'd0,
    SW_RUN  = 2'd1,
    SW_DONE = 2'd2
  } sweep_state_e;
endpackage

// File: rtl/rcan_store.sv
module rcan_store #(
  parameter int ROWS = 8,
  parameter int COLS = 16,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      wr_sel,
  input  logic [RW-1:0]             wr_row,
  input  logic [COLS-1:0]           wr_data,
  output logic [ROWS-1:0][COLS-1:0] tab_base,
  output logic [ROWS-1:0][COLS-1:0] tab_next
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tab_base <= '0;
      tab_next <= '0;
    end else if (wr_en && (int'(wr_row) < ROWS)) begin
      if (wr_sel) tab_next[wr_row] <= wr_data;
      else        tab_base[wr_row] <= wr_data;
    end
  end
endmodule

// File: rtl/rcan_overlap.sv
module rcan_overlap #(
  parameter int ROWS = 8,
  parameter int COLS = 16,
  localparam int KW = $clog2(COLS)
) (
  input  logic [ROWS-1:0][COLS-1:0] tab_base,
  input  logic [ROWS-1:0][COLS-1:0] tab_next,
  input  logic [KW-1:0]             shift,
  output logic                      self_hit,
  output logic                      app_hit
);
  // True when 'other' placed 'sh' columns later meets a busy cell of 'base'
  function automatic logic shifted_meet(input logic [COLS-1:0] base,
                                        input logic [COLS-1:0] other,
                                        input logic [KW-1:0]   sh);
    return |((base >> sh) & other);
  endfunction

  logic [ROWS-1:0] self_row;
  logic [ROWS-1:0] app_row;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign self_row[r] = shifted_meet(tab_base[r], tab_base[r], shift);
    assign app_row[r]  = shifted_meet(tab_base[r], tab_next[r], shift);
  end

  // Offset 0 is not a latency: every busy cell meets itself there
  assign self_hit = (shift != '0) && (|self_row);
  assign app_hit  = |app_row;
endmodule

// File: rtl/rcan_sweep.sv
module rcan_sweep
  import rcan_pkg::*;
#(
  parameter int COLS = 16,
  localparam int KW = $clog2(COLS),
  localparam int OW = $clog2(COLS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            start,
  input  logic            self_hit,
  input  logic            app_hit,
  output logic [KW-1:0]   shift,
  output logic            last_step,
  output logic            busy,
  output logic            done,
  output logic [COLS-2:0] coll_vec,
  output logic [OW-1:0]   app_off,
  output logic            app_sat
);
  localparam logic [KW-1:0] LAST = KW'(COLS - 1);

  sweep_state_e st_q;
  logic [KW-1:0]   k_q;
  logic [COLS-2:0] coll_q;
  logic [OW-1:0]   off_q;
  logic            sat_q;
  logic            found_q;
  logic            step_en;
  logic            free_here;

  assign step_en   = (st_q == SW_RUN) && !clr && !start;
  assign last_step = step_en && (k_q == LAST);
  assign free_here = !app_hit && !found_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      st_q    <= SW_IDLE;
      k_q     <= '0;
      coll_q  <= '0;
      off_q   <= '0;
      sat_q   <= 1'b0;
      found_q <= 1'b0;
    end else if (start) begin
      st_q    <= SW_RUN;
      k_q     <= '0;
      coll_q  <= '0;
      off_q   <= '0;
      sat_q   <= 1'b0;
      found_q <= 1'b0;
    end else if (step_en) begin
      if (self_hit && (k_q != '0)) coll_q[k_q - 1'b1] <= 1'b1;
      if (free_here) begin
        found_q <= 1'b1;
        off_q   <= OW'(k_q);
      end
      if (k_q == LAST) begin
        st_q <= SW_DONE;
        if (!found_q && app_hit) begin
          sat_q <= 1'b1;
          off_q <= OW'(COLS);
        end
      end else begin
        k_q <= k_q + 1'b1;
      end
    end
  end

  assign shift    = k_q;
  assign busy     = (st_q == SW_RUN);
  assign done     = (st_q == SW_DONE);
  assign coll_vec = coll_q;
  assign app_off  = off_q;
  assign app_sat  = sat_q;
endmodule

// File: rtl/rcan_top.sv
module rcan_top #(
  parameter int ROWS = 8,
  parameter int COLS = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic                                 wr_sel,
  input  logic [((ROWS > 1) ? $clog2(ROWS) : 1)-1:0] wr_row,
  input  logic [COLS-1:0]                      wr_data,
  input  logic                                 start,
  output logic                                 busy,
  output logic                                 done,
  output logic [COLS-2:0]                      coll_vec,
  output logic [$clog2(COLS+1)-1:0]            app_off,
  output logic                                 app_sat
);
  localparam int KW = $clog2(COLS);

  logic [ROWS-1:0][COLS-1:0] tab_base;
  logic [ROWS-1:0][COLS-1:0] tab_next;
  logic [KW-1:0]             shift;
  logic                      self_hit;
  logic                      app_hit;
  logic                      last_step;

  rcan_store #(.ROWS(ROWS), .COLS(COLS)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_row(wr_row), .wr_data(wr_data),
    .tab_base(tab_base), .tab_next(tab_next)
  );

  rcan_overlap #(.ROWS(ROWS), .COLS(COLS)) u_overlap (
    .tab_base(tab_base), .tab_next(tab_next), .shift(shift),
    .self_hit(self_hit), .app_hit(app_hit)
  );

  rcan_sweep #(.COLS(COLS)) u_sweep (
    .clk(clk), .rst_n(rst_n), .clr(wr_en), .start(start),
    .self_hit(self_hit), .app_hit(app_hit),
    .shift(shift), .last_step(last_step),
    .busy(busy), .done(done), .coll_vec(coll_vec),
    .app_off(app_off), .app_sat(app_sat)
  );
endmodule

// File: rtl/rcan_checker.sv
module rcan_checker #(
  parameter int COLS = 16,
  localparam int OW = $clog2(COLS + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            start,
  input logic            last_step,
  input logic            busy,
  input logic            done,
  input logic [COLS-2:0] coll_vec,
  input logic [OW-1:0]   app_off,
  input logic            app_sat
);
  p_clear_results_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!done && !busy && coll_vec == '0 && app_off == '0 && !app_sat));

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !wr_en) |=> busy);

  p_last_step_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> (done && !busy));

  p_done_from_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  p_busy_done_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_off_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !app_sat) |-> (app_off < OW'(COLS)));

  p_sat_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    app_sat |-> (app_off == OW'(COLS)));

  p_write_beats_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && start) |=> !busy);
endmodule

bind rcan_top rcan_checker #(.COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .start(start),
  .last_step(last_step), .busy(busy), .done(done),
  .coll_vec(coll_vec), .app_off(app_off), .app_sat(app_sat)
);

// File: tb/rcan_top_tb.sv
`timescale 1ns/1ps
module rcan_top_tb;
  localparam int ROWS = 8;
  localparam int COLS = 16;
  localparam int RW = $clog2(ROWS);
  localparam int OW = $clog2(COLS + 1);

  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0, wr_sel = 0, start = 0;
  logic [RW-1:0] wr_row = '0;
  logic [COLS-1:0] wr_data = '0;
  logic busy, done, app_sat;
  logic [COLS-2:0] coll_vec;
  logic [OW-1:0] app_off;

  int checks = 0, errors = 0, cycles = 0;
  string scen = "R4";

  always #2.5 clk = ~clk;

  rcan_top #(.ROWS(ROWS), .COLS(COLS)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_row(wr_row), .wr_data(wr_data), .start(start),
    .busy(busy), .done(done), .coll_vec(coll_vec),
    .app_off(app_off), .app_sat(app_sat)
  );

  // Reference model state
  logic [COLS-1:0] ra [ROWS];
  logic [COLS-1:0] rb [ROWS];
  bit m_busy, m_done, m_sat;
  int m_cnt, m_off;
  logic [COLS-2:0] m_coll;

  function automatic logic [COLS-2:0] calc_coll();
    logic [COLS-2:0] v = '0;
    for (int k = 1; k < COLS; k++)
      for (int r = 0; r < ROWS; r++)
        for (int t = 0; t + k < COLS; t++)
          if (ra[r][t] && ra[r][t+k]) v[k-1] = 1'b1;
    return v;
  endfunction

  function automatic int calc_off();
    for (int s = 0; s < COLS; s++) begin
      bit ok = 1;
      for (int r = 0; r < ROWS; r++)
        for (int t = 0; t + s < COLS; t++)
          if (rb[r][t] && ra[r][t+s]) ok = 0;
      if (ok) return s;
    end
    return COLS;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) begin ra[r] = '0; rb[r] = '0; end
      m_busy = 0; m_done = 0; m_sat = 0; m_cnt = 0; m_off = 0; m_coll = '0;
    end else if (wr_en) begin
      if (wr_sel) rb[wr_row] = wr_data; else ra[wr_row] = wr_data;
      m_busy = 0; m_done = 0; m_sat = 0; m_off = 0; m_coll = '0;
    end else if (start) begin
      m_busy = 1; m_done = 0; m_cnt = 0; m_sat = 0; m_off = 0; m_coll = '0;
    end else if (m_busy) begin
      m_cnt++;
      if (m_cnt == COLS) begin
        m_busy = 0; m_done = 1;
        m_coll = calc_coll();
        m_off = calc_off();
        m_sat = (m_off == COLS);
      end
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (busy !== m_busy || done !== m_done) begin
        errors++;
        $display("FAIL R3 (%s) busy/done actual=%b%b expected=%b%b at cycle %0d",
                 scen, busy, done, m_busy, m_done, cycles);
      end
      if (!m_busy) begin
        checks++;
        if (coll_vec !== m_coll) begin
          errors++;
          $display("FAIL R4/%s coll_vec actual=%h expected=%h", scen, coll_vec, m_coll);
        end
        checks++;
        if (int'(app_off) != m_off || app_sat !== m_sat) begin
          errors++;
          $display("FAIL R6/R7 (%s) off/sat actual=%0d/%b expected=%0d/%b",
                   scen, app_off, app_sat, m_off, m_sat);
        end
      end
    end
  end

  task automatic put_row(input bit sel, input int row, input logic [COLS-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_row = RW'(row); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    for (int r = 0; r < ROWS; r++) begin
      put_row(0, r, '0);
      put_row(1, r, '0);
    end
  endtask

  task automatic expect_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_cycles(3);
    // R1: reset state
    expect_bit("R1 busy", busy, 1'b0);
    expect_bit("R1 done", done, 1'b0);
    expect_bit("R1 sat", app_sat, 1'b0);
    checks++;
    if (coll_vec !== '0 || app_off !== '0) begin
      errors++;
      $display("FAIL R1 results actual=%h/%0d expected=0/0", coll_vec, app_off);
    end
    rst_n = 1;
    wait_cycles(2);

    // R2/R4/R6: small four-stage table plus a second table
    scen = "R2";
    put_row(0, 0, 16'h0001); put_row(0, 1, 16'h0002);
    put_row(0, 2, 16'h000C); put_row(0, 3, 16'h0030);
    put_row(1, 0, 16'h0001); put_row(1, 2, 16'h0006);
    scen = "R4";
    pulse_start();
    wait_cycles(COLS + 2);
    expect_bit("R3 done after sweep", done, 1'b1);

    // R2: a write clears the results
    scen = "R2";
    put_row(1, 5, 16'h0000);
    expect_bit("R2 done cleared", done, 1'b0);

    // R5: only the last row holds busy cells
    scen = "R5";
    clear_all();
    put_row(0, ROWS - 1, 16'h0009);
    pulse_start();
    wait_cycles(COLS + 2);
    checks++;
    if (coll_vec !== 15'h0004) begin
      errors++;
      $display("FAIL R5 coll_vec actual=%h expected=0004", coll_vec);
    end
    // R6: empty second table appends at 0
    checks++;
    if (app_off !== '0 || app_sat !== 1'b0) begin
      errors++;
      $display("FAIL R6 empty next actual=%0d expected=0", app_off);
    end

    // R7: base row fully busy, second table busy at column 0
    scen = "R7";
    put_row(0, 0, 16'hFFFF);
    put_row(1, 0, 16'h0001);
    pulse_start();
    wait_cycles(COLS + 2);
    expect_bit("R7 sat", app_sat, 1'b1);

    // R8: write and start in the same cycle
    scen = "R8";
    @(negedge clk);
    wr_en = 1; start = 1; wr_sel = 0; wr_row = 3'd1; wr_data = 16'h0101;
    @(negedge clk);
    wr_en = 0; start = 0;
    expect_bit("R8 no sweep", busy, 1'b0);
    wait_cycles(4);
    expect_bit("R8 still idle", busy, 1'b0);

    // R9: restart in the middle of a sweep
    scen = "R9";
    pulse_start();
    wait_cycles(6);
    pulse_start();
    wait_cycles(COLS - 2);
    expect_bit("R9 busy before end", busy, 1'b1);
    wait_cycles(3);
    expect_bit("R9 done", done, 1'b1);

    // R4/R6: assorted tables
    for (int n = 0; n < 12; n++) begin
      scen = "R4";
      for (int r = 0; r < ROWS; r++) begin
        put_row(0, r, COLS'($urandom & $urandom & $urandom));
        put_row(1, r, COLS'($urandom & $urandom & $urandom & $urandom));
      end
      pulse_start();
      wait_cycles(COLS + 3);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule